// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Return Address Stack

This unit sits beside the fetch stage of a 32-bit RISC-V pipeline and gives, in the same cycle as the fetch address, a guess of whether the instruction there redirects control flow and where it goes. It combines three structures:

- a direction table of 2-bit saturating counters;
- a target buffer whose entries each carry a kind (conditional branch, unconditional jump or return);
- a circular return address stack.

For a hit on a return entry, the target comes from the top of the stack rather than from the stored address.

The execute stage trains the tables through an update port that carries the resolved PC, the instruction kind, the actual outcome and the actual target. Decode-side hints drive the stack: a call hint pushes a return address, and a return hint pops one. Table changes become visible to lookups on the cycle after the update. Flush control and the resolution compare logic belong to the surrounding pipeline.

Top module: `bpred_top`

## Requirements
- R1: After reset every counter is weakly-not-taken and every target entry is invalid, so any fetch address predicts not taken with next PC equal to fetch PC + 4. Whenever the prediction is not taken, the next PC is fetch PC + 4.
- R2: Both tables are indexed by PC[9:2]. A target entry hits only if it is valid and its tag equals PC[31:10], so two addresses sharing bits [9:2] but differing in bits [31:10] do not share a target entry.
- R3: Kind code 0 (conditional branch) is predicted taken only when the target entry hits and the counter's upper bit is 1. The counter encoding is 0 strongly-not-taken, 1 weakly-not-taken, 2 weakly-taken and 3 strongly-taken. A hit with a counter below 2 predicts not taken.
- R4: An update of kind 0 moves the indexed counter up by one when taken and down by one when not taken. The counter saturates at 3 and at 0. Updates of other kinds leave counters unchanged.
- R5: The target entry (valid, kind, tag, target) is written only by updates whose outcome is taken. A not-taken update leaves an existing entry untouched and creates no new one.
- R6: Kind code 1 (jump) is predicted taken whenever its entry hits, regardless of the counter, with the stored target as next PC.
- R7: Kind code 2 (return) is predicted taken whenever its entry hits. The next PC is the return stack top when the stack is non-empty, and the stored target when it is empty.
- R8: The return stack is last-in first-out: a push makes its address the new top, and a pop exposes the previously pushed address.
- R9: The stack holds 32 addresses. A push when full overwrites the oldest address, so after more than 32 pushes exactly the 32 most recent can be popped before the stack is empty.
- R10: A pop on an empty stack has no effect.
- R11: A push and a pop in the same cycle first pop and then push, replacing the top without changing the stack depth.
- R12: Lookups are combinational on the current table contents. An update or hint presented in a cycle affects predictions from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | output | 1 | Prediction that control flow leaves fetch_pc |
| pred_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Resolved-instruction update strobe from execute |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_kind | input | 2 | 0 conditional branch, 1 jump, 2 return |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved target address |
| call_push | input | 1 | Call hint: push call_ret_addr |
| call_ret_addr | input | 32 | Return address to push |
| ret_pop | input | 1 | Return hint: pop the stack |

## Verification
Every cycle, assertions check the following:
- no taken prediction is given without a target hit;
- a not-taken prediction falls through to the next word;
- a counter already at either limit stays there when pushed further in the same direction;
- every taken update leaves its entry valid;
- a push leaves its address on top;
- a pop on an empty stack changes nothing;
- a combined push and pop keeps the depth.

The bench's scenarios are needed for outcomes that take a history of events to show: the full counter trajectory through both saturation points, tag aliasing, target retention across not-taken updates, the choice between the stack top and the stored target as the stack empties, and the loss of the oldest address once the stack wraps.

// File: rtl/bp_pkg.sv
package bp_pkg;
    // Kind code carried by the update port and stored in each target entry
    typedef enum logic [1:0] {
        KIND_BRANCH = 2'd0,
        KIND_JUMP   = 2'd1,
        KIND_RETURN = 2'd2
    } bp_kind_e;

    // Direction counter encoding; upper bit means "taken"
    localparam logic [1:0] CTR_STRONG_NT = 2'd0;
    localparam logic [1:0] CTR_WEAK_NT   = 2'd1;
    localparam logic [1:0] CTR_WEAK_T    = 2'd2;
    localparam logic [1:0] CTR_STRONG_T  = 2'd3;
endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } dir_state_t;

    dir_state_t st_d, st_q;
    logic [1:0] cur_ctr;

    always_comb begin
        st_d    = st_q;
        cur_ctr = st_q.ctr[wr_idx];
        if (wr_en) begin
            if (wr_taken) begin
                if (cur_ctr != CTR_STRONG_T) st_d.ctr[wr_idx] = cur_ctr + 2'd1;
            end else begin
                if (cur_ctr != CTR_STRONG_NT) st_d.ctr[wr_idx] = cur_ctr - 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {ENTRIES{CTR_WEAK_NT}};
        else        st_q <= st_d;
    end

    assign rd_taken = st_q.ctr[rd_idx][1];

    AST_CTR_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && st_q.ctr[wr_idx] == CTR_STRONG_T)
        |=> st_q.ctr[$past(wr_idx)] == CTR_STRONG_T); // R4
    AST_CTR_HOLD_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && st_q.ctr[wr_idx] == CTR_STRONG_NT)
        |=> st_q.ctr[$past(wr_idx)] == CTR_STRONG_NT); // R4
endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic [XLEN-IDX_W-3:0]   rd_tag,
    output logic                    rd_hit,
    output logic [1:0]              rd_kind,
    output logic [XLEN-1:0]         rd_target,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [XLEN-IDX_W-3:0]   wr_tag,
    input  logic [1:0]              wr_kind,
    input  logic [XLEN-1:0]         wr_target
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = XLEN - IDX_W - 2;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][1:0]       kind;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][XLEN-1:0]  tgt;
    } btb_state_t;

    btb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_idx]  = 1'b1;
            st_d.kind[wr_idx] = wr_kind;
            st_d.tag[wr_idx]  = wr_tag;
            st_d.tgt[wr_idx]  = wr_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_hit    = st_q.vld[rd_idx] && (st_q.tag[rd_idx] == rd_tag);
    assign rd_kind   = st_q.kind[rd_idx];
    assign rd_target = st_q.tgt[rd_idx];

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.vld[$past(wr_idx)]); // R5
endmodule

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [XLEN-1:0] push_addr,
    input  logic            pop,
    output logic [XLEN-1:0] top,
    output logic            nonempty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0]            ptr;   // next free slot
        logic [CNT_W-1:0]            cnt;   // live entries
        logic [DEPTH-1:0][XLEN-1:0]  mem;
    } ras_state_t;

    ras_state_t st_d, st_q;
    logic [PTR_W-1:0] slot;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_LAST : p - PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        slot = st_q.ptr;
        // pop first, so a combined call-return replaces the top
        if (pop && st_q.cnt != '0) begin
            slot     = ptr_dec(st_q.ptr);
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (push) begin
            st_d.mem[slot] = push_addr;
            st_d.ptr       = ptr_inc(slot);
            if (st_d.cnt != CNT_FULL) st_d.cnt = st_d.cnt + CNT_W'(1);
        end else begin
            st_d.ptr = slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top      = st_q.mem[ptr_dec(st_q.ptr)];
    assign nonempty = (st_q.cnt != '0);

    AST_PUSH_BECOMES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top == $past(push_addr)); // R8
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL); // R9
    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == '0) |=> (st_q.cnt == '0) && $stable(st_q.ptr)); // R10
    AST_SWAP_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push && st_q.cnt != '0) |=> $stable(st_q.cnt)); // R11
endmodule

// File: rtl/bpred_top.sv
module bpred_top
    import bp_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int IDX_W     = 8,
    parameter int RAS_DEPTH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     fetch_pc,
    output logic            pred_taken,
    output logic [31:0]     pred_pc,
    input  logic            upd_valid,
    input  logic [31:0]     upd_pc,
    input  logic [1:0]      upd_kind,
    input  logic            upd_taken,
    input  logic [31:0]     upd_target,
    input  logic            call_push,
    input  logic [31:0]     call_ret_addr,
    input  logic            ret_pop
);
    localparam int TAG_LO = IDX_W + 2;
    localparam int TAG_W  = XLEN - TAG_LO;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             dir_taken, btb_hit, ras_nonempty;
    logic [1:0]       btb_kind;
    logic [XLEN-1:0]  btb_target, ras_top;
    logic             dir_wr, btb_wr;
    logic             unused_low_bits;

    assign f_idx = fetch_pc[TAG_LO-1:2];
    assign f_tag = fetch_pc[XLEN-1:TAG_LO];
    assign u_idx = upd_pc[TAG_LO-1:2];
    assign u_tag = upd_pc[XLEN-1:TAG_LO];
    assign unused_low_bits = ^upd_pc[1:0];

    assign dir_wr = upd_valid && (bp_kind_e'(upd_kind) == KIND_BRANCH);
    assign btb_wr = upd_valid && upd_taken;

    bp_dir_table #(.IDX_W(IDX_W)) i_dir (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_idx), .rd_taken(dir_taken),
        .wr_en(dir_wr), .wr_idx(u_idx), .wr_taken(upd_taken)
    );

    bp_target_buf #(.XLEN(XLEN), .IDX_W(IDX_W)) i_btb (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_idx), .rd_tag(f_tag),
        .rd_hit(btb_hit), .rd_kind(btb_kind), .rd_target(btb_target),
        .wr_en(btb_wr), .wr_idx(u_idx), .wr_tag(u_tag),
        .wr_kind(upd_kind), .wr_target(upd_target)
    );

    bp_ret_stack #(.XLEN(XLEN), .DEPTH(RAS_DEPTH)) i_ras (
        .clk(clk), .rst_n(rst_n),
        .push(call_push), .push_addr(call_ret_addr), .pop(ret_pop),
        .top(ras_top), .nonempty(ras_nonempty)
    );

    always_comb begin
        pred_taken = 1'b0;
        pred_pc    = fetch_pc + 32'd4;
        if (btb_hit) begin
            unique case (bp_kind_e'(btb_kind))
                KIND_BRANCH: begin
                    pred_taken = dir_taken;
                    if (dir_taken) pred_pc = btb_target;
                end
                KIND_RETURN: begin
                    pred_taken = 1'b1;
                    pred_pc    = ras_nonempty ? ras_top : btb_target;
                end
                default: begin
                    pred_taken = 1'b1;
                    pred_pc    = btb_target;
                end
            endcase
        end
    end

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> btb_hit); // R3
    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_pc == fetch_pc + 32'd4); // R1
endmodule

// File: tb/test_bpred_top.sv
module test_bpred_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken;
    logic [31:0] pred_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [1:0]  upd_kind = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        call_push = 1'b0;
    logic [31:0] call_ret_addr = '0;
    logic        ret_pop = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [31:0] P_BR   = 32'h0000_1040;
    localparam logic [31:0] T_BR   = 32'h0000_8000;
    localparam logic [31:0] T_BAD  = 32'h0000_9990;
    localparam logic [31:0] P_JMP  = 32'h0000_3080;
    localparam logic [31:0] T_JMP  = 32'h0000_A000;
    localparam logic [31:0] P_RET  = 32'h0000_40C0;
    localparam logic [31:0] T_RET  = 32'h0000_B000;
    localparam logic [31:0] P_NEW  = 32'h0000_5100;
    localparam logic [31:0] P_AL1  = 32'h0000_6200;
    localparam logic [31:0] P_AL2  = 32'h0000_7200;
    localparam logic [31:0] T_AL   = 32'h0000_C000;

    always #5 clk = ~clk;

    bpred_top i_bpred_top (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_pc(pred_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_kind(upd_kind),
        .upd_taken(upd_taken), .upd_target(upd_target),
        .call_push(call_push), .call_ret_addr(call_ret_addr), .ret_pop(ret_pop)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic look(input string req, input logic [31:0] pc,
                        input logic exp_taken, input logic [31:0] exp_pc);
        fetch_pc = pc;
        #1;
        check(req, "taken", {31'b0, pred_taken}, {31'b0, exp_taken});
        check(req, "next pc", pred_pc, exp_pc);
    endtask

    task automatic update(input logic [31:0] pc, input logic [1:0] kind,
                          input logic taken, input logic [31:0] tgt);
        upd_valid = 1'b1; upd_pc = pc; upd_kind = kind;
        upd_taken = taken; upd_target = tgt;
        @(posedge clk); #1;
        upd_valid = 1'b0;
    endtask

    task automatic hint(input logic psh, input logic [31:0] addr, input logic pp);
        call_push = psh; call_ret_addr = addr; ret_pop = pp;
        @(posedge clk); #1;
        call_push = 1'b0; ret_pop = 1'b0;
    endtask

    task automatic t_reset;
        look("R1", P_BR, 1'b0, P_BR + 32'd4);
        look("R1", P_RET, 1'b0, P_RET + 32'd4);
    endtask

    task automatic t_branch_counter;
        // R12: update pending in this cycle is not yet visible
        upd_valid = 1'b1; upd_pc = P_BR; upd_kind = 2'd0;
        upd_taken = 1'b1; upd_target = T_BR;
        look("R12", P_BR, 1'b0, P_BR + 32'd4);
        @(posedge clk); #1;
        upd_valid = 1'b0;
        look("R12", P_BR, 1'b1, T_BR);              // counter 2
        update(P_BR, 2'd0, 1'b1, T_BR);             // 3
        update(P_BR, 2'd0, 1'b1, T_BR);             // stays 3
        update(P_BR, 2'd0, 1'b0, T_BAD);            // 2
        look("R4", P_BR, 1'b1, T_BR);               // top saturation held
        look("R5", P_BR, 1'b1, T_BR);               // not-taken target ignored
        update(P_BR, 2'd0, 1'b0, T_BAD);            // 1
        look("R3", P_BR, 1'b0, P_BR + 32'd4);       // hit, counter not taken
        update(P_BR, 2'd0, 1'b0, T_BAD);            // 0
        update(P_BR, 2'd0, 1'b0, T_BAD);            // stays 0
        update(P_BR, 2'd1, 1'b0, T_BAD);            // jump kind: counter untouched
        update(P_BR, 2'd0, 1'b1, T_BR);             // 1
        look("R4", P_BR, 1'b0, P_BR + 32'd4);       // bottom saturation held
        update(P_BR, 2'd0, 1'b1, T_BR);             // 2
        look("R4", P_BR, 1'b1, T_BR);
    endtask

    task automatic t_alias;
        update(P_AL1, 2'd0, 1'b1, T_AL);
        look("R2", P_AL2, 1'b0, P_AL2 + 32'd4);
        look("R2", P_AL1, 1'b1, T_AL);
    endtask

    task automatic t_no_fill;
        update(P_NEW, 2'd1, 1'b0, T_BAD);
        look("R5", P_NEW, 1'b0, P_NEW + 32'd4);
    endtask

    task automatic t_jump;
        update(P_JMP, 2'd1, 1'b1, T_JMP);
        look("R6", P_JMP, 1'b1, T_JMP);
    endtask

    task automatic t_return;
        update(P_RET, 2'd2, 1'b1, T_RET);
        look("R7", P_RET, 1'b1, T_RET);             // empty stack: stored target
        hint(1'b0, '0, 1'b1);                       // pop on empty
        look("R10", P_RET, 1'b1, T_RET);
        hint(1'b1, 32'h0000_0100, 1'b0);
        look("R10", P_RET, 1'b1, 32'h0000_0100);    // a phantom pop would lose this
        look("R7", P_RET, 1'b1, 32'h0000_0100);
        hint(1'b1, 32'h0000_0200, 1'b1);            // combined pop then push
        look("R11", P_RET, 1'b1, 32'h0000_0200);
        hint(1'b0, '0, 1'b1);
        look("R11", P_RET, 1'b1, T_RET);            // depth stayed 1
    endtask

    task automatic t_nested;
        hint(1'b1, 32'h0000_0A00, 1'b0);
        hint(1'b1, 32'h0000_0B00, 1'b0);
        hint(1'b1, 32'h0000_0C00, 1'b0);
        look("R8", P_RET, 1'b1, 32'h0000_0C00);
        hint(1'b0, '0, 1'b1);
        look("R8", P_RET, 1'b1, 32'h0000_0B00);
        hint(1'b0, '0, 1'b1);
        look("R8", P_RET, 1'b1, 32'h0000_0A00);
        hint(1'b0, '0, 1'b1);
        look("R8", P_RET, 1'b1, T_RET);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 33; i++) hint(1'b1, 32'h0001_0000 + 32'(i * 4), 1'b0);
        look("R9", P_RET, 1'b1, 32'h0001_0000 + 32'd128);
        for (int i = 0; i < 31; i++) hint(1'b0, '0, 1'b1);
        look("R9", P_RET, 1'b1, 32'h0001_0004);     // oldest (index 0) was lost
        hint(1'b0, '0, 1'b1);
        look("R9", P_RET, 1'b1, T_RET);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_branch_counter();
        t_alias();
        t_no_fill();
        t_jump();
        t_return();
        t_nested();
        t_overflow();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule